// File: doc/BRIEF.md
# Saturating Decimal Millisecond Stopwatch

This block measures elapsed time as a five-digit decimal value in the form XX.XXX seconds, with one step per millisecond. It runs from a single fast system clock. An internal counter divides that clock into a one-cycle millisecond enable, so the timing never relies on a slowed or derived clock. The count advances only while the run input is high. When the run input goes low, both the count and the divider phase are frozen.

The count is held as packed BCD, with the thousandths digit in the lowest nibble. Display logic can therefore take each digit directly. When the value reaches the configured ceiling (14.999 by default), the count stops and stays there, and a saturated flag goes high. While saturated, all LED outputs blink in unison with a 50 % duty cycle (4 Hz at the default setting) until reset. Seven-segment encoding and finish-time capture are done by neighbouring logic.

Top module: `bcd_stopwatch`

## Requirements
- R1: While rst_n is low at a rising edge, the count goes to 00.000, saturated_o goes low and every LED bit goes low.
- R2: Every 4-bit digit of digits_o stays in 0..9. A digit that steps past 9 returns to 0 and increments the next higher digit in the same cycle.
- R3: With run_i high and the block not saturated, the count rises by exactly one after every TICK_DIV rising edges. The first step comes TICK_DIV edges after run_i is first seen high following reset.
- R4: Edges with run_i low change neither the count nor the progress toward the next step. Those edges are simply skipped.
- R5: The count stops at LIMIT_BCD (default 20'h14999, meaning 14.999) and holds there. saturated_o is high exactly when digits_o equals LIMIT_BCD.
- R6: While not saturated, all LEDs are dark. Once saturated, they stay dark for FLASH_HALF edges, then change state every FLASH_HALF edges. At the defaults this gives 125 ms lit and 125 ms dark.
- R7: All LED bits always carry the same value.
- R8: A reset applied while saturated returns the block to R1's state, and a new run then counts from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz at default divider values) |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Count while high, pause while low |
| digits_o | output | 4*NDIG | Packed BCD count, thousandths digit in bits 3:0 |
| saturated_o | output | 1 | High while the count sits at the ceiling |
| leds_o | output | LED_W | LED drive, all bits blinking together when saturated |

## Verification
The hardest state to reach is the saturated ceiling, together with the blink phase that follows it. Getting there takes the full 14,999 steps with every carry chain in between. The bench shrinks the millisecond divider to four edges and the blink half-period to six. It then sweeps the whole count range, with periodic pauses on run_i, and compares every cycle against an arithmetic model of elapsed run edges. The model also counts edges since saturation, which gives the expected LED phase. After a few blink periods, the bench resets from inside saturation and restarts the count.

// File: rtl/stopwatch_pkg.sv
// Shared types and constants for the decimal stopwatch.
// Assumes every digit is a 4-bit BCD nibble.
package stopwatch_pkg;
    localparam int unsigned BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/ms_tick_gen.sv
// Millisecond enable generator: emits a one-cycle pulse after DIV enabled
// edges. Its phase is frozen while en_i is low.
// Assumes DIV >= 2, so pulses are never on adjacent cycles.
module ms_tick_gen #(
    parameter int unsigned DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(DIV);

    logic [CW-1:0] phase_q;
    logic          wrap;

    assign wrap   = (phase_q == CW'(DIV - 1));
    assign tick_o = en_i && wrap;

    // Advance the phase only on enabled edges; restart it after a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (en_i)
            phase_q <= wrap ? '0 : phase_q + 1'b1;
    end

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    a_r4_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(phase_q));
endmodule

// File: rtl/bcd_digit.sv
// One decimal digit cell: increments on inc_i and wraps 9 -> 0.
// It drives carry_o in the same cycle so the next cell steps with it.
// Assumes a synchronous active-low reset.
module bcd_digit
    import stopwatch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    output bcd_t digit_o,
    output logic carry_o
);
    bcd_t digit_q;

    assign digit_o = digit_q;
    assign carry_o = inc_i && (digit_q == BCD_TOP);

    // Step the digit on request, wrapping from nine back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            digit_q <= '0;
        else if (inc_i)
            digit_q <= (digit_q == BCD_TOP) ? '0 : digit_q + 1'b1;
    end

    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= BCD_TOP);
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && digit_q == BCD_TOP) |=> digit_q == '0);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(digit_q));
endmodule

// File: rtl/bcd_chain.sv
// Ripple-carry chain of NDIG decimal digits, least significant first.
// Assumes step_i is a one-cycle pulse.
module bcd_chain
    import stopwatch_pkg::*;
#(
    parameter int unsigned NDIG = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    output logic [BCD_W*NDIG-1:0] digits_o
);
    logic [NDIG:0] carry;

    assign carry[0] = step_i;

    // One cell per digit; each cell's carry feeds the next one up.
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        bcd_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (carry[g]),
            .digit_o (digits_o[g*BCD_W +: BCD_W]),
            .carry_o (carry[g+1])
        );
    end
endmodule

// File: rtl/led_flasher.sv
// Blinks all LED_W outputs together while active_i is high: dark for the
// first HALF edges, then toggling every HALF edges. Dark when inactive.
// Assumes HALF >= 2.
module led_flasher #(
    parameter int unsigned HALF  = 6250000,
    parameter int unsigned LED_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    output logic [LED_W-1:0] leds_o
);
    localparam int unsigned CW = $clog2(HALF);

    logic [CW-1:0] span_q;
    logic          lit_q;

    assign leds_o = {LED_W{lit_q}};

    // Time the half-period and flip the lamp state at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            span_q <= '0;
            lit_q  <= 1'b0;
        end else if (span_q == CW'(HALF - 1)) begin
            span_q <= '0;
            lit_q  <= ~lit_q;
        end else begin
            span_q <= span_q + 1'b1;
        end
    end

    a_r6_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && span_q == CW'(HALF - 1)) |=> lit_q != $past(lit_q));
endmodule

// File: rtl/bcd_stopwatch.sv
// Saturating BCD stopwatch top: millisecond enable, digit chain, ceiling
// compare and LED blinker. Assumes TICK_DIV >= 2, FLASH_HALF >= 2, and a
// LIMIT_BCD made of valid BCD nibbles.
module bcd_stopwatch
    import stopwatch_pkg::*;
#(
    parameter int unsigned           NDIG       = 5,
    parameter int unsigned           TICK_DIV   = 50000,
    parameter int unsigned           FLASH_HALF = 6250000,
    parameter int unsigned           LED_W      = 10,
    parameter logic [4*NDIG-1:0]     LIMIT_BCD  = 20'h14999
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    output logic [BCD_W*NDIG-1:0] digits_o,
    output logic                  saturated_o,
    output logic [LED_W-1:0]      leds_o
);
    logic tick_en;
    logic ms_tick;

    assign saturated_o = (digits_o == LIMIT_BCD);
    assign tick_en     = run_i && !saturated_o;

    ms_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (ms_tick)
    );

    bcd_chain #(.NDIG(NDIG)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (ms_tick),
        .digits_o (digits_o)
    );

    led_flasher #(.HALF(FLASH_HALF), .LED_W(LED_W)) u_flash (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (saturated_o),
        .leds_o   (leds_o)
    );

    // Check once that the ceiling is made of decimal digits.
    initial begin
        for (int i = 0; i < int'(NDIG); i++)
            a_r5_limit_decimal: assert (LIMIT_BCD[i*4 +: 4] <= 4'd9);
    end

    a_r5_hold_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        saturated_o |=> saturated_o && $stable(digits_o));
    a_r4_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(digits_o));
    a_r6_dark_below: assert property (@(posedge clk) disable iff (!rst_n)
        !saturated_o |-> leds_o == '0);
    a_r7_leds_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (leds_o == '0) || (leds_o == '1));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (digits_o == '0) && !saturated_o && (leds_o == '0));
endmodule

// File: tb/test_bcd_stopwatch.sv
// Full-range sweep with a small divider configuration; the expected values
// come from an arithmetic model of elapsed run edges.
module test_bcd_stopwatch;
    localparam int DIV   = 4;
    localparam int HALF  = 6;
    localparam int ND    = 5;
    localparam int LW    = 10;
    localparam int LIMIT = 14999;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            run;
    logic [4*ND-1:0] digits;
    logic            sat;
    logic [LW-1:0]   leds;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int ms, ph, nsat;

    always #2 clk = ~clk;

    bcd_stopwatch #(
        .NDIG(ND), .TICK_DIV(DIV), .FLASH_HALF(HALF), .LED_W(LW),
        .LIMIT_BCD(20'h14999)
    ) i_bcd_stopwatch (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .digits_o(digits), .saturated_o(sat), .leds_o(leds)
    );

    function automatic logic [4*ND-1:0] to_bcd(int v);
        logic [4*ND-1:0] r = '0;
        for (int i = 0; i < ND; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One edge with the given run level; update the model, then compare.
    task automatic cycle(bit r);
        bit pre_sat;
        bit exp_lit;
        run = r;
        pre_sat = (ms == LIMIT);
        @(posedge clk);
        if (r && ms < LIMIT) begin
            ph++;
            if (ph == DIV) begin
                ph = 0;
                ms++;
            end
        end
        if (pre_sat) nsat++;
        #1;
        exp_lit = ((nsat / HALF) % 2) == 1;
        check(digits == to_bcd(ms), "R3", int'(digits), int'(to_bcd(ms)));
        check(sat == (ms == LIMIT), "R5", int'(sat), int'(ms == LIMIT));
        check(leds == (exp_lit ? {LW{1'b1}} : {LW{1'b0}}), "R6",
              int'(leds), exp_lit ? (1 << LW) - 1 : 0);
        check(leds == '0 || leds == '1, "R7", int'(leds), 0);
        for (int i = 0; i < ND; i++)
            check(digits[i*4 +: 4] <= 4'd9, "R2", int'(digits[i*4 +: 4]), 9);
    endtask

    initial begin
        rst_n = 1'b0;
        run   = 1'b0;
        ms = 0; ph = 0; nsat = 0;
        repeat (3) @(posedge clk);
        #1;
        check(digits == '0, "R1", int'(digits), 0);
        check(sat == 1'b0, "R1", int'(sat), 0);
        check(leds == '0, "R1", int'(leds), 0);
        rst_n = 1'b1;
        // R4: partial phase, then a long pause, must not lose or add edges.
        for (int i = 0; i < 3; i++) cycle(1'b1);
        for (int i = 0; i < 10; i++) cycle(1'b0);
        check(digits == '0, "R4", int'(digits), 0);
        cycle(1'b1);
        check(digits == to_bcd(1), "R4", int'(digits), int'(to_bcd(1)));
        // R3/R5/R6: sweep to the ceiling with periodic pauses, then blink.
        for (int c = 0; !(ms == LIMIT && nsat > 5 * HALF); c++)
            cycle((c % 211) >= 7);
        // R8: reset from inside saturation, then count again.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        ms = 0; ph = 0; nsat = 0;
        check(digits == '0 && !sat && leds == '0, "R8",
              int'(digits), 0);
        for (int i = 0; i < 2000; i++) cycle(1'b1);
        check(digits == to_bcd(500), "R8", int'(digits), int'(to_bcd(500)));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", ms, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule